// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block gives software access to an interrupt router's routing table through an indirect register pair. A bus master first writes an 8-bit selector at one offset, then reads or writes a 32-bit data window at a second offset. The selector chooses among an identification register, a fixed read-only version word, and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves, the low half through an even selector and the high half through the following odd selector.

Every table entry is driven at all times onto a wide parallel bus for a downstream dispatcher. Each time software writes half of a valid entry, the block raises a one-cycle service request so that the dispatcher can re-evaluate pending interrupts. After reset every entry has its mask bit (bit 16) set, so no pin can be delivered until software programs it.

Top module: `irq_window`

## Requirements
- R1: Only the low 8 bits of `bus_addr` are decoded. Offset 0x00 writes `bus_wdata[7:0]` into the selector and reads it back in bits 7:0 with zeros above. Offset 0x10 is the data window. Any other offset reads zero and ignores writes.
- R2: Selector 0x00 is the ID register. A window write stores `bus_wdata[31:24]`, and a window read returns the ID in bits 31:24 with zeros below.
- R3: Selector 0x01 reads 0x00170011, which is version 0x11 in bits 7:0 and the highest entry number (23) in bits 23:16. Window writes to it change nothing.
- R4: Selector 0x02, and every selector from 0x03 to 0x0F, reads zero through the window and ignores window writes.
- R5: For selectors of 0x10 and above, the entry number is (selector − 0x10) >> 1. An even selector maps to entry bits 31:0 and an odd selector maps to entry bits 63:32.
- R6: A window access whose entry number is 24 or higher reads zero, leaves every entry unchanged and raises no service request.
- R7: A window write to one half of a valid entry changes only that half of that entry.
- R8: `svc_req` is high for exactly the one cycle after the clock edge that accepts a window write to a valid entry half. It stays low for every other access.
- R9: Synchronous reset clears the selector, the ID, `bus_rdata` and `svc_req`, and sets every entry to 0x0000_0000_0001_0000.
- R10: Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`. It holds that value until the next read.
- R11: Entry k is driven continuously on `entry_bus[64k+63:64k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Bus address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| entry_bus | output | 1536 | All 24 redirection entries, entry k at bits 64k+63:64k |
| svc_req | output | 1 | One-cycle service request after a valid entry write |

## Verification
The bound checker verifies several rules on every cycle:
- the reset values on the outputs;
- that read data holds between reads;
- that a service request occurs exactly when a window write lands on an in-range entry;
- that writes to other offsets, or to out-of-range entries, leave the table untouched.

Only the bench's scenarios can show that the data is correct. These cover the value decoded for each selector class, the even/odd half mapping, preservation of the other half, the version word, and the return to the masked reset state after a reset in mid-run.

// File: rtl/irq_window_pkg.sv
package irq_window_pkg;

  localparam int          WORD_W      = 32;
  localparam int          ENTRY_W     = 64;
  localparam logic [7:0]  OFF_SELECT  = 8'h00;
  localparam logic [7:0]  OFF_WINDOW  = 8'h10;
  localparam logic [7:0]  SEL_IDENT   = 8'h00;
  localparam logic [7:0]  SEL_VERSION = 8'h01;
  localparam logic [7:0]  SEL_ENTRY0  = 8'h10;

  typedef enum logic [1:0] {
    TGT_ZERO  = 2'd0,
    TGT_IDENT = 2'd1,
    TGT_VER   = 2'd2,
    TGT_ENTRY = 2'd3
  } win_tgt_t;

endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
  import irq_window_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int IDX_W       = 5
) (
  input  logic [7:0]       off,
  input  logic [7:0]       sel,
  output logic             hit_sel,
  output logic             hit_win,
  output win_tgt_t         tgt,
  output logic [IDX_W-1:0] ent_idx,
  output logic             ent_hi
);

  localparam logic [6:0] LIMIT = 7'(NUM_ENTRIES);

  logic [7:0] rel;
  logic [6:0] ent_num;

  always_comb begin
    hit_sel = (off == OFF_SELECT);
    hit_win = (off == OFF_WINDOW);
    rel     = sel - SEL_ENTRY0;
    ent_num = rel[7:1];
    ent_idx = ent_num[IDX_W-1:0];
    ent_hi  = sel[0];
    if (sel == SEL_IDENT)
      tgt = TGT_IDENT;
    else if (sel == SEL_VERSION)
      tgt = TGT_VER;
    else if ((sel >= SEL_ENTRY0) && (ent_num < LIMIT))
      tgt = TGT_ENTRY;
    else
      tgt = TGT_ZERO;
  end

endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
  import irq_window_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter int          IDX_W       = 5,
  parameter logic [31:0] RST_LO      = 32'h0001_0000,
  parameter logic [31:0] RST_HI      = 32'h0000_0000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_hi,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [NUM_ENTRIES*ENTRY_W-1:0] entries
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic              hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= RST_LO;
        hi_q <= RST_HI;
      end else if (hit) begin
        if (wr_hi) hi_q <= wr_data;
        else       lo_q <= wr_data;
      end
    end

    assign entries[g*ENTRY_W +: ENTRY_W] = {hi_q, lo_q};
  end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_window_pkg::*;
#(
  parameter int         NUM_ENTRIES = 24,
  parameter int         IDX_W       = 5,
  parameter logic [7:0] VERSION     = 8'h11
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic                           hit_sel,
  input  logic                           hit_win,
  input  win_tgt_t                       tgt,
  input  logic [IDX_W-1:0]               ent_idx,
  input  logic                           ent_hi,
  input  logic [7:0]                     sel,
  input  logic [7:0]                     ident,
  input  logic [NUM_ENTRIES*ENTRY_W-1:0] entries,
  output logic [WORD_W-1:0]              rdata
);

  localparam logic [7:0] MAX_ENTRY = 8'(NUM_ENTRIES - 1);

  logic [ENTRY_W-1:0] ent_word;
  logic [WORD_W-1:0]  rd_next;

  always_comb begin
    ent_word = entries[int'(ent_idx)*ENTRY_W +: ENTRY_W];
    rd_next  = '0;
    if (hit_sel) begin
      rd_next = {24'h0, sel};
    end else if (hit_win) begin
      case (tgt)
        TGT_IDENT: rd_next = {ident, 24'h0};
        TGT_VER:   rd_next = {8'h0, MAX_ENTRY, 8'h0, VERSION};
        TGT_ENTRY: rd_next = ent_hi ? ent_word[63:32] : ent_word[31:0];
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

endmodule

// File: rtl/irq_window.sv
module irq_window
  import irq_window_pkg::*;
#(
  parameter int         NUM_ENTRIES = 24,
  parameter int         ADDR_W      = 12,
  parameter logic [7:0] VERSION     = 8'h11
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic [NUM_ENTRIES*64-1:0]      entry_bus,
  output logic                           svc_req
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [7:0]       sel_q;
  logic [7:0]       ident_q;
  logic             svc_q;
  logic             hit_sel;
  logic             hit_win;
  win_tgt_t         tgt;
  logic [IDX_W-1:0] ent_idx;
  logic             ent_hi;
  logic             ent_wr;

  irq_win_decode #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_decode (
    .off     (bus_addr[7:0]),
    .sel     (sel_q),
    .hit_sel (hit_sel),
    .hit_win (hit_win),
    .tgt     (tgt),
    .ent_idx (ent_idx),
    .ent_hi  (ent_hi)
  );

  assign ent_wr = bus_wr && hit_win && (tgt == TGT_ENTRY);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      ident_q <= '0;
      svc_q   <= 1'b0;
    end else begin
      if (bus_wr && hit_sel)
        sel_q <= bus_wdata[7:0];
      if (bus_wr && hit_win && (tgt == TGT_IDENT))
        ident_q <= bus_wdata[31:24];
      svc_q <= ent_wr;
    end
  end

  irq_entry_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ent_wr),
    .wr_idx  (ent_idx),
    .wr_hi   (ent_hi),
    .wr_data (bus_wdata),
    .entries (entry_bus)
  );

  irq_read_port #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .VERSION(VERSION)) u_read (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd),
    .hit_sel (hit_sel),
    .hit_win (hit_win),
    .tgt     (tgt),
    .ent_idx (ent_idx),
    .ent_hi  (ent_hi),
    .sel     (sel_q),
    .ident   (ident_q),
    .entries (entry_bus),
    .rdata   (bus_rdata)
  );

  assign svc_req = svc_q;

endmodule

// File: rtl/irq_window_chk.sv
module irq_window_chk #(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [31:0]               bus_rdata,
  input logic [NUM_ENTRIES*64-1:0] entry_bus,
  input logic                      svc_req,
  input logic [7:0]                sel_q
);

  logic       past_ok = 1'b0;
  logic       rst_d   = 1'b0;
  logic [7:0] rel;
  logic [6:0] ent_num;
  logic       win_wr;
  logic       good_wr;
  logic       far_wr;

  always_ff @(posedge clk) begin
    rst_d   <= rst;
    past_ok <= !rst;
  end

  assign rel     = sel_q - 8'h10;
  assign ent_num = rel[7:1];
  assign win_wr  = bus_wr && (bus_addr[7:0] == 8'h10);
  assign good_wr = win_wr && (sel_q >= 8'h10) && (ent_num < 7'(NUM_ENTRIES));
  assign far_wr  = win_wr && (sel_q >= 8'h10) && (ent_num >= 7'(NUM_ENTRIES));

  // R9: outputs at their reset values right after a reset cycle
  assert_reset_R9: assert property (@(posedge clk)
    rst_d |-> (bus_rdata == 32'h0 && !svc_req && entry_bus[63:0] == 64'h1_0000));

  // R10: read data holds when no read was sampled
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(bus_rd)) |-> $stable(bus_rdata));

  // R8: a request only follows a window write that landed on the table range
  assert_svc_cause_R8: assert property (@(posedge clk) disable iff (rst)
    svc_req |-> (past_ok && $past(good_wr)));

  // R8: every valid entry write is followed by a request
  assert_svc_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(good_wr)) |-> svc_req);

  // R1: writes at non-window offsets never touch the table
  assert_offset_table_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(bus_wr && bus_addr[7:0] != 8'h10)) |-> $stable(entry_bus));

  // R6: out-of-range entry writes never touch the table
  assert_far_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(far_wr)) |-> ($stable(entry_bus) && !svc_req));

endmodule

bind irq_window irq_window_chk #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .entry_bus (entry_bus),
  .svc_req   (svc_req),
  .sel_q     (sel_q)
);

// File: tb/test_irq_window.sv
module test_irq_window;

  localparam int NE = 24;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [11:0]     bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NE*64-1:0] entry_bus;
  logic            svc_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_window i_irq_window (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .entry_bus (entry_bus),
    .svc_req   (svc_req)
  );

  typedef struct packed {
    logic        is_rd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'h0000_0000, 4'd9},  // R9 selector reset
    '{1'b0, 12'h000, 32'h0000_0001, 4'd0},
    '{1'b1, 12'h010, 32'h0017_0011, 4'd3},  // R3 version word
    '{1'b0, 12'h010, 32'hFFFF_FFFF, 4'd0},
    '{1'b1, 12'h010, 32'h0017_0011, 4'd3},  // R3 write ignored
    '{1'b0, 12'h000, 32'h0000_0000, 4'd0},
    '{1'b1, 12'h010, 32'h0000_0000, 4'd9},  // R9 ID reset
    '{1'b0, 12'h010, 32'hA512_3456, 4'd0},
    '{1'b1, 12'h010, 32'hA500_0000, 4'd2},  // R2 ID field
    '{1'b0, 12'h000, 32'h0000_0002, 4'd0},
    '{1'b0, 12'h010, 32'hFFFF_FFFF, 4'd0},
    '{1'b1, 12'h010, 32'h0000_0000, 4'd4},  // R4 selector 0x02
    '{1'b0, 12'h000, 32'h0000_000F, 4'd0},
    '{1'b1, 12'h010, 32'h0000_0000, 4'd4},  // R4 selector 0x0F
    '{1'b0, 12'h000, 32'h0000_0010, 4'd0},
    '{1'b1, 12'h010, 32'h0001_0000, 4'd9},  // R9 entry 0 low
    '{1'b0, 12'h000, 32'h0000_0011, 4'd0},
    '{1'b1, 12'h010, 32'h0000_0000, 4'd9},  // R9 entry 0 high
    '{1'b0, 12'h000, 32'h0000_003E, 4'd0},
    '{1'b0, 12'h010, 32'h0000_00C3, 4'd0},
    '{1'b1, 12'h010, 32'h0000_00C3, 4'd5},  // R5 entry 23 low
    '{1'b0, 12'h000, 32'h0000_003F, 4'd0},
    '{1'b0, 12'h010, 32'h5A00_0000, 4'd0},
    '{1'b1, 12'h010, 32'h5A00_0000, 4'd5},  // R5 entry 23 high
    '{1'b0, 12'h000, 32'h0000_003E, 4'd0},
    '{1'b1, 12'h010, 32'h0000_00C3, 4'd7},  // R7 low half kept
    '{1'b0, 12'h000, 32'h0000_0040, 4'd0},
    '{1'b0, 12'h010, 32'h1234_5678, 4'd0},
    '{1'b1, 12'h010, 32'h0000_0000, 4'd6},  // R6 entry 24 reads zero
    '{1'b1, 12'h300, 32'h0000_0040, 4'd1},  // R1 upper address bits ignored
    '{1'b0, 12'h020, 32'h0000_DEAD, 4'd0},
    '{1'b1, 12'h020, 32'h0000_0000, 4'd1},  // R1 other offset reads zero
    '{1'b1, 12'h000, 32'h0000_0040, 4'd1}   // R1 selector unchanged
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] got);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    got      = bus_rdata;
  endtask

  function automatic logic [63:0] entry(input int k);
    return entry_bus[k*64 +: 64];
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check("R9 rdata", 64'(bus_rdata), 64'h0);
    check("R9 svc", 64'(svc_req), 64'h0);
    for (int k = 0; k < NE; k++)
      check($sformatf("R9 entry %0d", k), entry(k), 64'h0000_0000_0001_0000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) begin
        do_rd(VECS[i].addr, got);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(got), 64'(VECS[i].data));
      end else begin
        do_wr(VECS[i].addr, VECS[i].data);
      end
    end

    // R11 entry placement on the parallel bus, R6 other entries untouched
    check("R11 entry 23", entry(23), 64'h5A00_0000_0000_00C3);
    check("R11 entry 22", entry(22), 64'h0000_0000_0001_0000);
    check("R6 entry 0", entry(0), 64'h0000_0000_0001_0000);

    // R8 service request
    do_wr(12'h000, 32'h12);
    check("R8 no svc on select write", 64'(svc_req), 64'h0);
    do_wr(12'h010, 32'h0000_0020);
    check("R8 svc pulse", 64'(svc_req), 64'h1);
    @(negedge clk);
    check("R8 svc one cycle", 64'(svc_req), 64'h0);
    check("R7 entry 1 low only", entry(1), 64'h0000_0000_0000_0020);
    do_wr(12'h000, 32'h13);
    do_wr(12'h010, 32'h0000_0077);
    check("R8 svc pulse high half", 64'(svc_req), 64'h1);
    check("R7 entry 1 high only", entry(1), 64'h0000_0077_0000_0020);
    do_wr(12'h000, 32'h50);
    do_wr(12'h010, 32'hFFFF_FFFF);
    check("R6 no svc out of range", 64'(svc_req), 64'h0);
    do_wr(12'h000, 32'h01);
    do_wr(12'h010, 32'hFFFF_FFFF);
    check("R8 no svc version write", 64'(svc_req), 64'h0);

    // R10 read data held until next read
    do_rd(12'h010, got);
    check("R10 read version", 64'(got), 64'h0017_0011);
    do_wr(12'h000, 32'h00);
    repeat (3) @(negedge clk);
    check("R10 rdata held", 64'(bus_rdata), 64'h0017_0011);

    // R9 reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 rdata after reset", 64'(bus_rdata), 64'h0);
    check("R9 entry 23 after reset", entry(23), 64'h0000_0000_0001_0000);
    check("R9 entry 1 after reset", entry(1), 64'h0000_0000_0001_0000);
    do_rd(12'h000, got);
    check("R9 selector after reset", 64'(got), 64'h0);
    do_rd(12'h010, got);
    check("R9 ID after reset", 64'(got), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule